// File: doc/BRIEF.md
# Speculative Load Queue with Commit, Squash and Blocked-Load Tracking

This block keeps the in-flight loads of an out-of-order core in program order. The rename or dispatch stage writes one entry for each load, tagged with its sequence number and an uncacheable flag. The entry goes into the tail of a circular array. Entries leave the head only when the commit stage retires loads up to a given sequence number. A branch or exception recovery squashes every entry younger than a given sequence number and pulls the tail back to match.

The array holds one slot in reserve as a sentinel, so at most `DEPTH-1` loads are held at once. An allocation attempt while full is dropped and latches a sticky overflow error. The issue path asks whether a load in a given slot may go to memory. A cacheable load in a live slot is granted. An uncacheable load is granted only when it sits at the head and the pipeline says it has reached commit. Otherwise the load is bounced back with a fault indication.

A small state machine tracks the oldest load that the memory port refused. It has four states:
- `BLK_IDLE`: nothing is blocked and not handled.
- `BLK_PENDING`: a load is blocked and not yet handled.
- `BLK_HANDLED`: the blocked load has been handled.
- `BLK_RELEASED`: the block was cleared after being handled.

Its transitions are:
- accept-refusal: any state goes to `BLK_PENDING`.
- mark-handled: `BLK_PENDING` goes to `BLK_HANDLED`, and `BLK_IDLE` goes to `BLK_RELEASED`.
- drop-block: `BLK_PENDING` goes to `BLK_IDLE`, and `BLK_HANDLED` goes to `BLK_RELEASED`.
- handled-and-dropped: `BLK_PENDING` goes to `BLK_RELEASED`.

Top module: `load_queue`

## Requirements
- R1: After reset the queue reports count 0, not full, head sequence 0, and overflow, blocked, handled and recorded-blocked-sequence all 0.
- R2: A valid allocation, with no squash in the same cycle and the queue not full, appends the load at the tail and raises the count by one in the next cycle. The tail wraps from slot DEPTH-1 to slot 0. `full` is 1 exactly when the count equals DEPTH-1, the sentinel slot being never used.
- R3: An allocation while full is dropped and sets `overflow_err`, which then stays 1 until reset. Fullness is judged before any commit in the same cycle.
- R4: A commit retires, in order from the head, every held load whose sequence number is less than or equal to `commit_seq`. The head then advances by that number of loads, and allocation in the same cycle still applies.
- R5: A squash removes every held load whose sequence number is greater than `squash_seq`, and the tail then follows the last survivor. A squash takes priority: an allocation or commit presented in the same cycle is ignored and does not set the overflow error.
- R6: `head_seq` shows the sequence number of the head load and reads 0 when the queue is empty.
- R7: For an uncacheable load, `issue_grant` is 1 only when its slot is the head slot and `issue_at_commit` is 1. In every other case `issue_fault` is 1 instead. Both outputs are combinational in the request cycle.
- R8: For a cacheable load in a live slot, `issue_grant` is 1 and `issue_fault` is 0. For a slot index that holds no live load, both outputs are 0. Slot k is the physical array position k, counted from 0.
- R9: A memory refusal is accepted when nothing is blocked, or when the refused load is older, meaning it has a smaller sequence number than the recorded one. On acceptance the next cycle shows `blocked` 1, `handled` 0 and `blocked_seq` equal to the refused sequence number.
- R10: While `blocked` is 1, a refusal from a load with a sequence number greater than or equal to the recorded one changes none of `blocked`, `handled` or `blocked_seq`.
- R11: `handled_set` sets `handled` and `blocked_clr` clears `blocked`, each independently. An accepted refusal in the same cycle overrides both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocate a load at the tail |
| alloc_seq | input | SEQ_W | Sequence number of the new load |
| alloc_uncache | input | 1 | New load is uncacheable |
| commit_valid | input | 1 | Retire loads up to commit_seq |
| commit_seq | input | SEQ_W | Youngest sequence number to retire |
| squash_valid | input | 1 | Discard loads younger than squash_seq |
| squash_seq | input | SEQ_W | Youngest sequence number that survives |
| issue_valid | input | 1 | Issue request for one slot |
| issue_idx | input | IDX_W | Slot being issued |
| issue_at_commit | input | 1 | Requesting load has reached commit |
| issue_grant | output | 1 | Load may access memory |
| issue_fault | output | 1 | Load is sent back with a fault indication |
| refuse_valid | input | 1 | Memory port refused a load |
| refuse_seq | input | SEQ_W | Sequence number of the refused load |
| blocked_clr | input | 1 | Clear the blocked flag |
| handled_set | input | 1 | Set the handled flag |
| count | output | CNT_W | Number of held loads |
| full | output | 1 | Count equals DEPTH-1 |
| head_seq | output | SEQ_W | Sequence number at the head, 0 when empty |
| overflow_err | output | 1 | Sticky allocation-while-full error |
| blocked | output | 1 | A refused load is recorded |
| handled | output | 1 | The refused load has been handled |
| blocked_seq | output | SEQ_W | Sequence number of the recorded refused load |

## Verification
The checker assumes that allocated sequence numbers rise strictly and never wrap. Commit and squash depend on the held loads being sorted by age. The stimulus therefore draws every new sequence number from a rising series of constants, and never reuses a squashed number. The issue checks assume the index points at a physical slot below DEPTH. The bench only offers such indices, and it includes live slots, the head slot and a free slot.

// File: rtl/lq_pkg.sv
package lq_pkg;

    typedef enum logic [1:0] {
        BLK_IDLE     = 2'd0,
        BLK_PENDING  = 2'd1,
        BLK_HANDLED  = 2'd2,
        BLK_RELEASED = 2'd3
    } blk_state_e;

endpackage

// File: rtl/lq_ring.sv
module lq_ring #(
    parameter int DEPTH = 8,
    parameter int SEQ_W = 16,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_valid,
    input  logic [SEQ_W-1:0] alloc_seq,
    input  logic             alloc_uncache,
    input  logic             commit_valid,
    input  logic [SEQ_W-1:0] commit_seq,
    input  logic             squash_valid,
    input  logic [SEQ_W-1:0] squash_seq,
    output logic [DEPTH-1:0] slot_live,
    output logic [DEPTH-1:0] slot_unc,
    output logic [IDX_W-1:0] head_ptr,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic [SEQ_W-1:0] head_seq,
    output logic             overflow_err
);

    localparam int CAP = DEPTH - 1;

    logic [SEQ_W-1:0] seq_mem [DEPTH];
    logic [DEPTH-1:0] live_q, live_d;
    logic [DEPTH-1:0] unc_q;
    logic [IDX_W-1:0] head_q, head_d, tail_q, tail_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             ovf_q;
    logic [DEPTH-1:0] retire_mask, keep_mask;
    logic [CNT_W-1:0] n_retire, n_keep;
    logic             alloc_ok;

    function automatic logic [IDX_W-1:0] ring_add(input logic [IDX_W-1:0] p,
                                                  input logic [CNT_W-1:0] n);
        logic [CNT_W:0] s;
        s = (CNT_W+1)'(p) + (CNT_W+1)'(n);
        if (s >= (CNT_W+1)'(DEPTH)) s = s - (CNT_W+1)'(DEPTH);
        return IDX_W'(s);
    endfunction

    function automatic logic [CNT_W-1:0] ones(input logic [DEPTH-1:0] v);
        logic [CNT_W-1:0] c;
        c = '0;
        for (int i = 0; i < DEPTH; i++) c = c + CNT_W'(v[i]);
        return c;
    endfunction

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_slot_cmp
            assign retire_mask[g] = commit_valid && live_q[g] && (seq_mem[g] <= commit_seq);
            assign keep_mask[g]   = live_q[g] && (seq_mem[g] <= squash_seq);
        end
    endgenerate

    assign full     = (cnt_q >= CNT_W'(CAP));
    assign alloc_ok = alloc_valid && !squash_valid && !full;
    assign n_retire = ones(retire_mask);
    assign n_keep   = ones(keep_mask);

    always_comb begin
        live_d = live_q;
        head_d = head_q;
        tail_d = tail_q;
        cnt_d  = cnt_q;
        if (squash_valid) begin
            live_d = keep_mask;
            tail_d = ring_add(head_q, n_keep);
            cnt_d  = n_keep;
        end else begin
            live_d = live_q & ~retire_mask;
            head_d = ring_add(head_q, n_retire);
            if (alloc_ok) begin
                live_d[tail_q] = 1'b1;
                tail_d         = ring_add(tail_q, CNT_W'(1));
            end
            cnt_d = cnt_q - n_retire + CNT_W'(alloc_ok);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q <= '0;
            head_q <= '0;
            tail_q <= '0;
            cnt_q  <= '0;
            ovf_q  <= 1'b0;
        end else begin
            live_q <= live_d;
            head_q <= head_d;
            tail_q <= tail_d;
            cnt_q  <= cnt_d;
            if (alloc_valid && !squash_valid && full) ovf_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unc_q <= '0;
        end else if (alloc_ok) begin
            seq_mem[tail_q] <= alloc_seq;
            unc_q[tail_q]   <= alloc_uncache;
        end
    end

    assign slot_live    = live_q;
    assign slot_unc     = unc_q;
    assign head_ptr     = head_q;
    assign count        = cnt_q;
    assign head_seq     = live_q[head_q] ? seq_mem[head_q] : '0;
    assign overflow_err = ovf_q;

endmodule

// File: rtl/lq_issue_gate.sv
module lq_issue_gate #(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             issue_valid,
    input  logic [IDX_W-1:0] issue_idx,
    input  logic             issue_at_commit,
    input  logic [DEPTH-1:0] slot_live,
    input  logic [DEPTH-1:0] slot_unc,
    input  logic [IDX_W-1:0] head_ptr,
    output logic             issue_grant,
    output logic             issue_fault
);

    logic in_range, live, unc, may_go;

    always_comb begin
        in_range = (32'(issue_idx) < DEPTH);
        live     = issue_valid && in_range && slot_live[issue_idx];
        unc      = slot_unc[issue_idx];
        may_go   = (issue_idx == head_ptr) && issue_at_commit;
        issue_grant = live && (!unc || may_go);
        issue_fault = live && unc && !may_go;
    end

endmodule

// File: rtl/lq_block_fsm.sv
module lq_block_fsm #(
    parameter int SEQ_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             refuse_valid,
    input  logic [SEQ_W-1:0] refuse_seq,
    input  logic             blocked_clr,
    input  logic             handled_set,
    output logic             blocked,
    output logic             handled,
    output logic [SEQ_W-1:0] blocked_seq
);

    import lq_pkg::*;

    blk_state_e       state_q, state_d;
    logic [SEQ_W-1:0] rec_q;
    logic             is_blocked, accept;

    assign is_blocked = (state_q == BLK_PENDING) || (state_q == BLK_HANDLED);
    assign accept     = refuse_valid && (!is_blocked || (refuse_seq < rec_q));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BLK_IDLE: begin
                if (accept)           state_d = BLK_PENDING;
                else if (handled_set) state_d = BLK_RELEASED;
            end
            BLK_PENDING: begin
                if (accept)                           state_d = BLK_PENDING;
                else if (handled_set && blocked_clr)  state_d = BLK_RELEASED;
                else if (handled_set)                 state_d = BLK_HANDLED;
                else if (blocked_clr)                 state_d = BLK_IDLE;
            end
            BLK_HANDLED: begin
                if (accept)           state_d = BLK_PENDING;
                else if (blocked_clr) state_d = BLK_RELEASED;
            end
            BLK_RELEASED: begin
                if (accept)           state_d = BLK_PENDING;
            end
            default: state_d = BLK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BLK_IDLE;
            rec_q   <= '0;
        end else begin
            state_q <= state_d;
            if (accept) rec_q <= refuse_seq;
        end
    end

    always_comb begin
        blocked = 1'b0;
        handled = 1'b0;
        unique case (state_q)
            BLK_IDLE:     begin blocked = 1'b0; handled = 1'b0; end
            BLK_PENDING:  begin blocked = 1'b1; handled = 1'b0; end
            BLK_HANDLED:  begin blocked = 1'b1; handled = 1'b1; end
            BLK_RELEASED: begin blocked = 1'b0; handled = 1'b1; end
            default:      begin blocked = 1'b0; handled = 1'b0; end
        endcase
    end

    assign blocked_seq = rec_q;

endmodule

// File: rtl/load_queue.sv
module load_queue #(
    parameter int DEPTH = 8,
    parameter int SEQ_W = 16,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_valid,
    input  logic [SEQ_W-1:0] alloc_seq,
    input  logic             alloc_uncache,
    input  logic             commit_valid,
    input  logic [SEQ_W-1:0] commit_seq,
    input  logic             squash_valid,
    input  logic [SEQ_W-1:0] squash_seq,
    input  logic             issue_valid,
    input  logic [IDX_W-1:0] issue_idx,
    input  logic             issue_at_commit,
    output logic             issue_grant,
    output logic             issue_fault,
    input  logic             refuse_valid,
    input  logic [SEQ_W-1:0] refuse_seq,
    input  logic             blocked_clr,
    input  logic             handled_set,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic [SEQ_W-1:0] head_seq,
    output logic             overflow_err,
    output logic             blocked,
    output logic             handled,
    output logic [SEQ_W-1:0] blocked_seq
);

    logic [DEPTH-1:0] slot_live, slot_unc;
    logic [IDX_W-1:0] head_ptr;

    lq_ring #(.DEPTH(DEPTH), .SEQ_W(SEQ_W)) u_ring (
        .clk          (clk),
        .rst_n        (rst_n),
        .alloc_valid  (alloc_valid),
        .alloc_seq    (alloc_seq),
        .alloc_uncache(alloc_uncache),
        .commit_valid (commit_valid),
        .commit_seq   (commit_seq),
        .squash_valid (squash_valid),
        .squash_seq   (squash_seq),
        .slot_live    (slot_live),
        .slot_unc     (slot_unc),
        .head_ptr     (head_ptr),
        .count        (count),
        .full         (full),
        .head_seq     (head_seq),
        .overflow_err (overflow_err)
    );

    lq_issue_gate #(.DEPTH(DEPTH)) u_gate (
        .issue_valid    (issue_valid),
        .issue_idx      (issue_idx),
        .issue_at_commit(issue_at_commit),
        .slot_live      (slot_live),
        .slot_unc       (slot_unc),
        .head_ptr       (head_ptr),
        .issue_grant    (issue_grant),
        .issue_fault    (issue_fault)
    );

    lq_block_fsm #(.SEQ_W(SEQ_W)) u_blk (
        .clk         (clk),
        .rst_n       (rst_n),
        .refuse_valid(refuse_valid),
        .refuse_seq  (refuse_seq),
        .blocked_clr (blocked_clr),
        .handled_set (handled_set),
        .blocked     (blocked),
        .handled     (handled),
        .blocked_seq (blocked_seq)
    );

endmodule

// File: rtl/lq_checker.sv
module lq_checker #(
    parameter int DEPTH = 8,
    parameter int SEQ_W = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             alloc_valid,
    input logic             commit_valid,
    input logic             squash_valid,
    input logic             refuse_valid,
    input logic [SEQ_W-1:0] refuse_seq,
    input logic             issue_valid,
    input logic             issue_grant,
    input logic             issue_fault,
    input logic [CNT_W-1:0] count,
    input logic             full,
    input logic [SEQ_W-1:0] head_seq,
    input logic             overflow_err,
    input logic             blocked,
    input logic             handled,
    input logic [SEQ_W-1:0] blocked_seq
);

    assert_count_cap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        32'(count) <= DEPTH - 1);

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (full && alloc_valid && !squash_valid) |=> overflow_err);

    assert_sticky_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_err |=> overflow_err);

    assert_commit_shrinks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_valid && !alloc_valid && !squash_valid) |=> count <= $past(count));

    assert_empty_head_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0) |-> (head_seq == '0));

    assert_issue_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({issue_grant, issue_fault}));

    assert_issue_needs_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_grant || issue_fault) |-> issue_valid);

    assert_first_refusal_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (refuse_valid && !blocked) |=>
            (blocked && !handled && blocked_seq == $past(refuse_seq)));

    assert_younger_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (refuse_valid && blocked && refuse_seq >= blocked_seq) |=>
            (blocked_seq == $past(blocked_seq)));

endmodule

bind load_queue lq_checker #(.DEPTH(DEPTH), .SEQ_W(SEQ_W)) u_lq_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .alloc_valid (alloc_valid),
    .commit_valid(commit_valid),
    .squash_valid(squash_valid),
    .refuse_valid(refuse_valid),
    .refuse_seq  (refuse_seq),
    .issue_valid (issue_valid),
    .issue_grant (issue_grant),
    .issue_fault (issue_fault),
    .count       (count),
    .full        (full),
    .head_seq    (head_seq),
    .overflow_err(overflow_err),
    .blocked     (blocked),
    .handled     (handled),
    .blocked_seq (blocked_seq)
);

// File: tb/load_queue_bench.sv
module load_queue_bench;

    localparam int DEPTH = 8;
    localparam int SEQ_W = 16;
    localparam int IDX_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int CAP   = DEPTH - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic             alloc_valid = 0, alloc_uncache = 0;
    logic [SEQ_W-1:0] alloc_seq = '0;
    logic             commit_valid = 0, squash_valid = 0;
    logic [SEQ_W-1:0] commit_seq = '0, squash_seq = '0;
    logic             issue_valid = 0, issue_at_commit = 0;
    logic [IDX_W-1:0] issue_idx = '0;
    logic             refuse_valid = 0, blocked_clr = 0, handled_set = 0;
    logic [SEQ_W-1:0] refuse_seq = '0;
    logic             issue_grant, issue_fault, full, overflow_err, blocked, handled;
    logic [CNT_W-1:0] count;
    logic [SEQ_W-1:0] head_seq, blocked_seq;

    int checks = 0;
    int errors = 0;

    int unsigned m_seq[$];
    bit          m_unc[$];
    int          m_head = 0;
    bit          m_ovf = 0, m_blk = 0, m_hnd = 0;
    int unsigned m_bseq = 0;

    always #10 clk = ~clk;

    load_queue #(.DEPTH(DEPTH), .SEQ_W(SEQ_W)) u_load_queue (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_seq(alloc_seq), .alloc_uncache(alloc_uncache),
        .commit_valid(commit_valid), .commit_seq(commit_seq),
        .squash_valid(squash_valid), .squash_seq(squash_seq),
        .issue_valid(issue_valid), .issue_idx(issue_idx), .issue_at_commit(issue_at_commit),
        .issue_grant(issue_grant), .issue_fault(issue_fault),
        .refuse_valid(refuse_valid), .refuse_seq(refuse_seq),
        .blocked_clr(blocked_clr), .handled_set(handled_set),
        .count(count), .full(full), .head_seq(head_seq), .overflow_err(overflow_err),
        .blocked(blocked), .handled(handled), .blocked_seq(blocked_seq)
    );

    task automatic check(input string req, input int unsigned act, input int unsigned exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic clear_inputs();
        alloc_valid = 0; alloc_uncache = 0; commit_valid = 0; squash_valid = 0;
        issue_valid = 0; issue_at_commit = 0; refuse_valid = 0;
        blocked_clr = 0; handled_set = 0;
    endtask

    task automatic model_step();
        bit was_full, acc;
        if (squash_valid) begin
            while (m_seq.size() > 0 && m_seq[m_seq.size()-1] > squash_seq) begin
                void'(m_seq.pop_back());
                void'(m_unc.pop_back());
            end
        end else begin
            was_full = (m_seq.size() >= CAP);
            if (commit_valid)
                while (m_seq.size() > 0 && m_seq[0] <= commit_seq) begin
                    void'(m_seq.pop_front());
                    void'(m_unc.pop_front());
                    m_head = (m_head + 1) % DEPTH;
                end
            if (alloc_valid) begin
                if (was_full) m_ovf = 1;
                else begin
                    m_seq.push_back(alloc_seq);
                    m_unc.push_back(alloc_uncache);
                end
            end
        end
        acc = refuse_valid && (!m_blk || refuse_seq < m_bseq);
        if (acc) begin
            m_blk = 1; m_hnd = 0; m_bseq = refuse_seq;
        end else begin
            if (handled_set) m_hnd = 1;
            if (blocked_clr) m_blk = 0;
        end
    endtask

    task automatic compare_state();
        check("R2 count", count, m_seq.size());
        check("R2 full", full, (m_seq.size() == CAP));
        check("R6 head_seq", head_seq, (m_seq.size() > 0) ? m_seq[0] : 0);
        check("R3 overflow_err", overflow_err, m_ovf);
        check("R9 blocked", blocked, m_blk);
        check("R11 handled", handled, m_hnd);
        check("R10 blocked_seq", blocked_seq, m_bseq);
    endtask

    // inputs are already set; check issue combinationally, clock, update model, compare
    task automatic tick();
        int pos;
        bit live, ok;
        #1;
        if (issue_valid) begin
            pos  = (int'(issue_idx) - m_head + DEPTH) % DEPTH;
            live = pos < m_seq.size();
            ok   = live && (!m_unc[pos] || (pos == 0 && issue_at_commit));
            check("R7 R8 issue_grant", issue_grant, ok);
            check("R7 issue_fault", issue_fault, live && m_unc[pos] && !(pos == 0 && issue_at_commit));
        end
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_state();
        clear_inputs();
    endtask

    task automatic do_alloc(input int unsigned s, input bit u);
        alloc_valid = 1; alloc_seq = SEQ_W'(s); alloc_uncache = u;
        tick();
    endtask

    task automatic do_issue(input int idx, input bit at_c);
        issue_valid = 1; issue_idx = IDX_W'(idx); issue_at_commit = at_c;
        tick();
    endtask

    task automatic do_refuse(input int unsigned s);
        refuse_valid = 1; refuse_seq = SEQ_W'(s);
        tick();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=expired expected=done");
        finish_run();
    end

    initial begin
        clear_inputs();
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        #1;
        check("R1 count", count, 0);
        check("R1 full", full, 0);
        check("R1 head_seq", head_seq, 0);
        check("R1 overflow", overflow_err, 0);
        check("R1 blocked", blocked, 0);
        check("R1 handled", handled, 0);
        check("R1 blocked_seq", blocked_seq, 0);
        @(negedge clk);

        // R2: fill to DEPTH-1, slot 3 (seq 40) uncacheable
        for (int i = 1; i <= CAP; i++) do_alloc(i * 10, i == 4);
        check("R2 full at cap", full, 1);
        // R3: allocate while full, commit in same cycle does not help
        alloc_valid = 1; alloc_seq = 16'd75; commit_valid = 1; commit_seq = 16'd5;
        tick();
        check("R3 overflow set", overflow_err, 1);
        // R8: cacheable live slot, free slot
        do_issue(1, 0);
        do_issue(7, 1);
        // R7: uncacheable not at head
        do_issue(3, 1);
        // R4: retire 10, 20
        commit_valid = 1; commit_seq = 16'd25; tick();
        check("R4 count after commit", count, 5);
        commit_valid = 1; commit_seq = 16'd35; tick();
        // R7: uncacheable at head, without and with commit
        do_issue(3, 0);
        do_issue(3, 1);
        // R2/R4: wrap tail while committing
        alloc_valid = 1; alloc_seq = 16'd80; commit_valid = 1; commit_seq = 16'd35; tick();
        do_alloc(90, 1);
        do_issue(0, 0);
        // R5: squash with alloc and commit in same cycle
        squash_valid = 1; squash_seq = 16'd55;
        alloc_valid = 1; alloc_seq = 16'd95; commit_valid = 1; commit_seq = 16'd45;
        tick();
        check("R5 count after squash", count, 2);
        do_alloc(100, 0);
        check("R5 head unchanged", head_seq, 40);
        // R6: drain
        commit_valid = 1; commit_seq = 16'd200; tick();
        check("R6 empty head", head_seq, 0);
        // R3: sticky across activity
        check("R3 still set", overflow_err, 1);

        // R9 R10 R11: blocked tracking
        do_refuse(500);
        do_refuse(600);
        check("R10 kept", blocked_seq, 500);
        handled_set = 1; tick();
        do_refuse(500);
        do_refuse(450);
        check("R9 older recorded", blocked_seq, 450);
        check("R9 handled cleared", handled, 0);
        blocked_clr = 1; tick();
        do_refuse(700);
        refuse_valid = 1; refuse_seq = 16'd650; blocked_clr = 1; handled_set = 1; tick();
        check("R11 refusal wins", blocked, 1);
        blocked_clr = 1; handled_set = 1; tick();
        handled_set = 1; tick();
        do_refuse(800);

        finish_run();
    end

endmodule